// File: doc/BRIEF.md
# Cart Price Tally Unit

This block keeps the running purchase total for a shopping cart. Each scan carries an 8-bit product identifier and a direction bit. The identifier selects a price in an internal writable table. The price is then added to the item subtotal or taken off it, so an item can be put back. Store coupons build up a separate discount sum. The discount is taken off the subtotal, with a floor at zero, before tax is applied.

Every accepted scan or coupon starts a tax calculation. A 16x5 fixed-point shift-and-add multiplier runs one partial product per cycle, with no pipelining. While it runs, `busy` is high and any new scan or coupon is dropped. When the multiply finishes, tax and total update together and `done` pulses. A separate load port rewrites table entries at any time, for example while the cart sits in its dock. A synchronous clear empties the cart and leaves the prices untouched.

Top module: `cart_tally`

## Requirements
- R1: After reset, `subtotal`, `tax` and `total` are zero, and `busy`, `done` and `error` are low.
- R2: A scan that is accepted with `scanRemove`=0 adds the table price of `scanId` to `subtotal`. The new value shows in the cycle after the accepting edge.
- R3: A scan that is accepted with `scanRemove`=1 subtracts the table price of `scanId` from `subtotal`. The new value shows in the cycle after the accepting edge.
- R4: If an add would go past 65535, `subtotal` saturates at 65535. If a remove would go below zero, `subtotal` saturates at 0. In both cases `error` is high for exactly the one cycle after the accepting edge.
- R5: An accepted coupon adds `couponAmt` to a coupon sum, which saturates at 65535. The net amount is max(subtotal − coupon sum, 0).
- R6: `tax` = (net × rate + 32) >> 6, where the rate is the `taxRate` value sampled on the accepting edge. `total` = net + tax and is 17 bits wide.
- R7: After an accepting edge, `busy` is high for exactly 5 cycles. In the cycle after that, `done` is high for one cycle, and `tax` and `total` take their new values at the same time.
- R8: Commands are accepted only when the unit is idle. A scan or coupon presented while `busy` is high is ignored. When a scan and a coupon arrive together on an idle cycle, the scan wins and the coupon is dropped.
- R9: `loadValid` writes `loadPrice` into entry `loadAddr` on any cycle, including while busy. A scan of the same entry on the same edge uses the old price, and later scans use the new one.
- R10: `clear` takes priority over everything else. It sets `subtotal`, the coupon sum, `tax` and `total` to zero, drops `busy` and `done`, and aborts any multiply in progress. The price table is left unchanged.
- R11: `tax` and `total` keep their values until the next `done` pulse or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous cart clear |
| scanValid | input | 1 | Scan command strobe |
| scanRemove | input | 1 | 1 = remove the item, 0 = add the item |
| scanId | input | 8 | Product identifier |
| couponValid | input | 1 | Coupon command strobe |
| couponAmt | input | 16 | Coupon discount in cents |
| taxRate | input | 5 | Tax rate in 1/64 steps |
| loadValid | input | 1 | Price table write strobe |
| loadAddr | input | 8 | Table entry to write |
| loadPrice | input | 16 | New price in cents |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse: tax and total updated |
| error | output | 1 | One-cycle pulse: subtotal saturated |
| subtotal | output | 16 | Item subtotal in cents |
| tax | output | 16 | Tax in cents |
| total | output | 17 | Net amount plus tax in cents |

## Verification
Two functions can land on the same clock edge. A table rewrite can hit the very entry that a scan is looking up, and a clear can arrive while the multiplier is partway through its steps. The bench provokes the first by driving `loadValid` and `scanValid` with the same identifier in one cycle. It then expects the subtotal to move by the old price on that scan and by the new price on the next scan. It provokes the second by asserting `clear` two cycles into a multiply. It then expects everything to zero at once, with no `done` pulse afterwards, and a following scan to return the untouched table price.

// File: rtl/cart_pkg.sv
package cart_pkg;
  localparam int STEP_W = 3;

  typedef struct packed {
    logic clearAll;
    logic doAdd;
    logic doRemove;
    logic doCoupon;
    logic startMul;
    logic mulStep;
    logic finish;
    logic [STEP_W-1:0] stepIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/cart_price_table.sv
module cart_price_table #(
  parameter int ID_W    = 8,
  parameter int PRICE_W = 16
) (
  input  logic               clk,
  input  logic               wrEn,
  input  logic [ID_W-1:0]    wrAddr,
  input  logic [PRICE_W-1:0] wrData,
  input  logic [ID_W-1:0]    rdAddr,
  output logic [PRICE_W-1:0] rdData
);
  localparam int DEPTH = 1 << ID_W;

  logic [PRICE_W-1:0] priceMem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) priceMem[wrAddr] <= wrData;
  end

  // read sees the value before any same-edge write
  assign rdData = priceMem[rdAddr];
endmodule

// File: rtl/cart_control.sv
module cart_control
  import cart_pkg::*;
#(
  parameter int RATE_W = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       scanValid,
  input  logic       scanRemove,
  input  logic       couponValid,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(RATE_W - 1);

  typedef enum logic {ST_IDLE, ST_MUL} state_t;

  state_t            state;
  logic [STEP_W-1:0] stepCnt;

  always_comb begin
    strobe = '0;
    if (clear) begin
      strobe.clearAll = 1'b1;
    end else if (state == ST_IDLE) begin
      if (scanValid) begin
        strobe.doAdd    = !scanRemove;
        strobe.doRemove = scanRemove;
        strobe.startMul = 1'b1;
      end else if (couponValid) begin
        strobe.doCoupon = 1'b1;
        strobe.startMul = 1'b1;
      end
    end else begin
      strobe.mulStep = 1'b1;
      strobe.stepIdx = stepCnt;
      strobe.finish  = (stepCnt == LAST_STEP);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.clearAll) begin
        state   <= ST_IDLE;
        stepCnt <= '0;
      end else if (strobe.startMul) begin
        state   <= ST_MUL;
        stepCnt <= '0;
      end else if (strobe.finish) begin
        state   <= ST_IDLE;
        stepCnt <= '0;
      end else if (strobe.mulStep) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  assign busy = (state == ST_MUL);

  // R8
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobe.startMul);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !$past(clear)) |-> done);

  // R8
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clearAll, strobe.doAdd, strobe.doRemove, strobe.doCoupon}));
endmodule

// File: rtl/cart_datapath.sv
module cart_datapath
  import cart_pkg::*;
#(
  parameter int PRICE_W = 16,
  parameter int RATE_W  = 5,
  parameter int FRAC_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [PRICE_W-1:0] price,
  input  logic [PRICE_W-1:0] couponAmt,
  input  logic [RATE_W-1:0]  taxRate,
  output logic [PRICE_W-1:0] subtotal,
  output logic [PRICE_W-1:0] tax,
  output logic [PRICE_W:0]   total,
  output logic               error
);
  localparam int ACC_W = PRICE_W + RATE_W;
  localparam logic [ACC_W-1:0] ROUND = ACC_W'(1) << (FRAC_W - 1);
  localparam logic [PRICE_W-1:0] MAXV = {PRICE_W{1'b1}};

  logic [PRICE_W-1:0] subQ, cpnQ, taxQ;
  logic [PRICE_W:0]   totQ;
  logic [RATE_W-1:0]  rateQ;
  logic [ACC_W-1:0]   accQ;
  logic               errQ;

  logic [PRICE_W:0]   addSum, cpnSum;
  logic               underflow;
  logic [PRICE_W-1:0] net, taxNext;
  logic [ACC_W-1:0]   addend, accSum;

  always_comb begin
    addSum    = {1'b0, subQ} + {1'b0, price};
    cpnSum    = {1'b0, cpnQ} + {1'b0, couponAmt};
    underflow = price > subQ;
    net       = (subQ > cpnQ) ? (subQ - cpnQ) : '0;
    addend    = rateQ[strobe.stepIdx] ? (ACC_W'(net) << strobe.stepIdx) : '0;
    accSum    = accQ + addend;
    taxNext   = PRICE_W'(accSum >> FRAC_W);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subQ  <= '0;
      cpnQ  <= '0;
      taxQ  <= '0;
      totQ  <= '0;
      rateQ <= '0;
      accQ  <= '0;
      errQ  <= 1'b0;
    end else begin
      errQ <= 1'b0;
      if (strobe.clearAll) begin
        subQ <= '0;
        cpnQ <= '0;
        taxQ <= '0;
        totQ <= '0;
        accQ <= '0;
      end else begin
        if (strobe.doAdd) begin
          subQ <= addSum[PRICE_W] ? MAXV : addSum[PRICE_W-1:0];
          errQ <= addSum[PRICE_W];
        end
        if (strobe.doRemove) begin
          subQ <= underflow ? '0 : (subQ - price);
          errQ <= underflow;
        end
        if (strobe.doCoupon) begin
          cpnQ <= cpnSum[PRICE_W] ? MAXV : cpnSum[PRICE_W-1:0];
        end
        if (strobe.startMul) begin
          rateQ <= taxRate;
          accQ  <= ROUND;
        end
        if (strobe.mulStep) accQ <= accSum;
        if (strobe.finish) begin
          taxQ <= taxNext;
          totQ <= {1'b0, net} + {1'b0, taxNext};
        end
      end
    end
  end

  assign subtotal = subQ;
  assign tax      = taxQ;
  assign total    = totQ;
  assign error    = errQ;

  // R4
  sat_on_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> (subQ == '0 || subQ == MAXV));

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (subQ == '0 && taxQ == '0 && totQ == '0 && !errQ));

  // R6
  total_covers_tax_chk: assert property (@(posedge clk) disable iff (!rstN)
    totQ >= {1'b0, taxQ});

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.finish || strobe.clearAll) |=> ($stable(taxQ) && $stable(totQ)));
endmodule

// File: rtl/cart_tally.sv
module cart_tally
  import cart_pkg::*;
#(
  parameter int ID_W    = 8,
  parameter int PRICE_W = 16,
  parameter int RATE_W  = 5,
  parameter int FRAC_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clear,
  input  logic               scanValid,
  input  logic               scanRemove,
  input  logic [ID_W-1:0]    scanId,
  input  logic               couponValid,
  input  logic [PRICE_W-1:0] couponAmt,
  input  logic [RATE_W-1:0]  taxRate,
  input  logic               loadValid,
  input  logic [ID_W-1:0]    loadAddr,
  input  logic [PRICE_W-1:0] loadPrice,
  output logic               busy,
  output logic               done,
  output logic               error,
  output logic [PRICE_W-1:0] subtotal,
  output logic [PRICE_W-1:0] tax,
  output logic [PRICE_W:0]   total
);
  ctlStrobe_t         strobe;
  logic [PRICE_W-1:0] tablePrice;

  cart_price_table #(.ID_W(ID_W), .PRICE_W(PRICE_W)) uTable (
    .clk(clk), .wrEn(loadValid), .wrAddr(loadAddr), .wrData(loadPrice),
    .rdAddr(scanId), .rdData(tablePrice)
  );

  cart_control #(.RATE_W(RATE_W)) uCtl (
    .clk(clk), .rstN(rstN), .clear(clear), .scanValid(scanValid),
    .scanRemove(scanRemove), .couponValid(couponValid),
    .strobe(strobe), .busy(busy), .done(done)
  );

  cart_datapath #(.PRICE_W(PRICE_W), .RATE_W(RATE_W), .FRAC_W(FRAC_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .price(tablePrice),
    .couponAmt(couponAmt), .taxRate(taxRate), .subtotal(subtotal),
    .tax(tax), .total(total), .error(error)
  );
endmodule

// File: tb/sim_cart_tally.sv
module sim_cart_tally;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clear = 1'b0;
  logic        scanValid = 1'b0;
  logic        scanRemove = 1'b0;
  logic [7:0]  scanId = '0;
  logic        couponValid = 1'b0;
  logic [15:0] couponAmt = '0;
  logic [4:0]  taxRate = '0;
  logic        loadValid = 1'b0;
  logic [7:0]  loadAddr = '0;
  logic [15:0] loadPrice = '0;
  logic        busy, done, error;
  logic [15:0] subtotal, tax;
  logic [16:0] total;

  int vectors = 0;
  int miscompares = 0;

  cart_tally u0 (
    .clk(clk), .rstN(rstN), .clear(clear), .scanValid(scanValid),
    .scanRemove(scanRemove), .scanId(scanId), .couponValid(couponValid),
    .couponAmt(couponAmt), .taxRate(taxRate), .loadValid(loadValid),
    .loadAddr(loadAddr), .loadPrice(loadPrice), .busy(busy), .done(done),
    .error(error), .subtotal(subtotal), .tax(tax), .total(total)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int priceOf(int i);
    return (i == 250) ? 60000 : ((i * 37 + 99) % 4000);
  endfunction

  function automatic int expTax(int s, int c, int r);
    int n = (s > c) ? s - c : 0;
    return (n * r + 32) / 64;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mMem [256];
  int mSub = 0, mCpn = 0, mTax = 0, mTot = 0, mBusy = 0, mRate = 0;
  int mDone = 0, mErr = 0;

  always @(posedge clk) begin
    int p, n;
    p = mMem[int'(scanId)];
    mErr = 0;
    mDone = 0;
    if (!rstN) begin
      mSub = 0; mCpn = 0; mTax = 0; mTot = 0; mBusy = 0;
    end else begin
      if (clear) begin
        mSub = 0; mCpn = 0; mTax = 0; mTot = 0; mBusy = 0;
      end else if (mBusy > 0) begin
        mBusy--;
        if (mBusy == 0) begin
          n = (mSub > mCpn) ? mSub - mCpn : 0;
          mTax = (n * mRate + 32) / 64;
          mTot = n + mTax;
          mDone = 1;
        end
      end else if (scanValid) begin
        if (scanRemove) begin
          if (p > mSub) begin mSub = 0; mErr = 1; end else mSub = mSub - p;
        end else begin
          if (mSub + p > 65535) begin mSub = 65535; mErr = 1; end else mSub = mSub + p;
        end
        mBusy = 5;
        mRate = int'(taxRate);
      end else if (couponValid) begin
        mCpn = (mCpn + int'(couponAmt) > 65535) ? 65535 : mCpn + int'(couponAmt);
        mBusy = 5;
        mRate = int'(taxRate);
      end
      if (loadValid) mMem[int'(loadAddr)] = int'(loadPrice);
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    check("R2", "subtotal", int'(subtotal), mSub);
    check("R6", "tax", int'(tax), mTax);
    check("R5", "total", int'(total), mTot);
    check("R7", "busy", int'(busy), (mBusy > 0) ? 1 : 0);
    check("R7", "done", int'(done), mDone);
    check("R4", "error", int'(error), mErr);
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic scan(int id, bit rem, int rate);
    scanValid = 1'b1; scanRemove = rem; scanId = 8'(id); taxRate = 5'(rate);
    tick();
    scanValid = 1'b0; scanRemove = 1'b0;
    repeat (5) tick();
  endtask

  task automatic coupon(int amt, int rate);
    couponValid = 1'b1; couponAmt = 16'(amt); taxRate = 5'(rate);
    tick();
    couponValid = 1'b0;
    repeat (5) tick();
  endtask

  task automatic doClear();
    clear = 1'b1;
    tick();
    clear = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    int s0, holdTax, holdTot;
    repeat (3) tick();
    // R1 reset state
    check("R1", "reset subtotal", int'(subtotal), 0);
    check("R1", "reset total", int'(total), 0);
    check("R1", "reset flags", int'({busy, done, error}), 0);
    rstN = 1'b1;
    tick();
    for (int i = 0; i < 256; i++) begin
      loadValid = 1'b1; loadAddr = 8'(i); loadPrice = 16'(priceOf(i));
      tick();
    end
    loadValid = 1'b0;

    // R2 adds, R6 tax with several rates
    scan(3, 1'b0, 5);
    check("R2", "add item 3", int'(subtotal), priceOf(3));
    scan(7, 1'b0, 31);
    scan(7, 1'b0, 0);
    check("R6", "rate zero tax", int'(tax), 0);
    // R3 remove
    scan(7, 1'b1, 17);
    check("R3", "remove item 7", int'(subtotal), priceOf(3) + priceOf(7));
    check("R6", "tax rate 17", int'(tax), expTax(priceOf(3) + priceOf(7), 0, 17));

    // R4 overflow then underflow
    scan(250, 1'b0, 9);
    scan(250, 1'b0, 9);
    check("R4", "overflow saturates", int'(subtotal), 65535);
    doClear();
    scan(11, 1'b0, 4);
    scan(250, 1'b1, 4);
    check("R4", "underflow saturates", int'(subtotal), 0);

    // R5 coupons with floor and sum saturation
    doClear();
    scan(40, 1'b0, 12);
    scan(41, 1'b0, 12);
    coupon(500, 12);
    check("R5", "coupon net total", int'(total),
          (priceOf(40) + priceOf(41) - 500) + expTax(priceOf(40) + priceOf(41), 500, 12));
    coupon(60000, 12);
    coupon(60000, 12);
    check("R5", "coupon floor", int'(total), 0);

    // R8 commands while busy are dropped; scan beats coupon
    doClear();
    scanValid = 1'b1; scanId = 8'd5; taxRate = 5'd20;
    tick();
    scanId = 8'd6;
    tick();
    couponValid = 1'b1; couponAmt = 16'd100;
    tick();
    scanValid = 1'b0; couponValid = 1'b0;
    repeat (4) tick();
    check("R8", "busy drops commands", int'(subtotal), priceOf(5));
    scanValid = 1'b1; couponValid = 1'b1; scanId = 8'd6; couponAmt = 16'd100;
    tick();
    scanValid = 1'b0; couponValid = 1'b0;
    repeat (5) tick();
    check("R8", "coupon dropped", int'(total),
          priceOf(5) + priceOf(6) + expTax(priceOf(5) + priceOf(6), 0, 20));

    // R9 same-edge rewrite of scanned entry
    doClear();
    scanValid = 1'b1; scanId = 8'd20; loadValid = 1'b1; loadAddr = 8'd20;
    loadPrice = 16'd1234; taxRate = 5'd8;
    tick();
    scanValid = 1'b0; loadValid = 1'b0;
    repeat (5) tick();
    check("R9", "collision uses old price", int'(subtotal), priceOf(20));
    s0 = int'(subtotal);
    // R9 load while busy
    scanValid = 1'b1; scanId = 8'd20;
    tick();
    scanValid = 1'b0;
    loadValid = 1'b1; loadAddr = 8'd21; loadPrice = 16'd777;
    tick();
    loadValid = 1'b0;
    repeat (4) tick();
    check("R9", "new price used", int'(subtotal), s0 + 1234);
    scan(21, 1'b0, 8);
    check("R9", "busy load took effect", int'(subtotal), s0 + 1234 + 777);

    // R11 results hold
    holdTax = int'(tax); holdTot = int'(total);
    repeat (10) tick();
    check("R11", "tax holds", int'(tax), holdTax);
    check("R11", "total holds", int'(total), holdTot);

    // R10 clear mid multiply keeps table
    scanValid = 1'b1; scanId = 8'd30; taxRate = 5'd25;
    tick();
    scanValid = 1'b0;
    tick();
    doClear();
    check("R10", "clear zeroes subtotal", int'(subtotal), 0);
    check("R10", "clear drops busy", int'(busy), 0);
    repeat (6) tick();
    check("R10", "no done after abort", int'(total), 0);
    scan(3, 1'b0, 25);
    check("R10", "table kept", int'(subtotal), priceOf(3));
    repeat (3) tick();
    finishRun();
  end
endmodule